// File: doc/BRIEF.md
# Shared-Bus Processor to AHB-Lite Master Bridge

This block sits between a load/store processor with one bidirectional data bus and an AHB-Lite master port. The AHB-Lite port has separate read and write data buses. The processor raises a request with an address and a read/write flag, and keeps them steady until the bridge answers with a one-cycle ready pulse. For a store, the processor drives the store value onto the shared bus. For a load, the processor releases the shared bus and the bridge drives the returned read data onto it.

Every access is a single word transfer. The address phase is presented to the bus in the same cycle that the request appears, as long as no earlier access is still in its data phase. Once a slave accepts the address, the access moves into its data phase. During the data phase the bridge drives either its registered write data or the shared bus, depending on whether that data-phase access is a write or a read. An error response at completion is reported to the processor on an error flag that rises together with the ready pulse. The bridge never retries an access.

Top module: `cpu_ahb_bridge`

## Requirements
- R1: While reset is asserted, and after it is released with no request, the bridge holds htrans at IDLE (2'b00), holds cpu_rdy and cpu_err low, and does not drive cpu_data. This applies even if cpu_req is high during reset.
- R2: When cpu_req is high and no access is in its data phase, the bridge drives htrans to NONSEQ (2'b10), haddr to cpu_addr and hwrite to cpu_wr in that same cycle. With no request pending, htrans is IDLE. No other htrans code is ever driven.
- R3: hsize is always the word code 3'b010. The two low address bits pass to haddr unchanged, with no alignment check.
- R4: An address phase is accepted only on an edge where hready is high. While hready is low, haddr, hwrite and htrans keep the values they had when the address phase was first presented, even if the processor changes cpu_addr or cpu_wr.
- R5: For a store, the value on cpu_data at the edge that accepts the address is driven on hwdata for the whole data phase. It stays unchanged through wait states even if the processor changes the shared bus.
- R6: For a load, the bridge drives hrdata onto cpu_data throughout that access's data phase, wait states included. It releases the bus once the data phase completes.
- R7: The bridge never drives cpu_data during a store data phase or while idle. During those times the shared bus carries the processor's value.
- R8: cpu_rdy is high for exactly one cycle: the data-phase cycle in which hready is high. A new request presented in the next cycle gets its NONSEQ address phase at once.
- R9: cpu_err is high, together with cpu_rdy, exactly when hresp is 1 in the completing cycle. After an error the bridge issues no new transfer unless the processor requests one.
- R10: At most one access is outstanding. While an access is in its data phase, htrans is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until cpu_rdy |
| cpu_addr | input | AW | Processor byte address |
| cpu_wr | input | 1 | 1 = store, 0 = load |
| cpu_data | inout | DW | Shared bidirectional processor data bus |
| cpu_rdy | output | 1 | One-cycle access completion pulse |
| cpu_err | output | 1 | Error response flag, valid with cpu_rdy |
| haddr | output | AW | Bus address |
| hwrite | output | 1 | Bus write flag |
| htrans | output | 2 | Bus transfer type (IDLE 2'b00, NONSEQ 2'b10) |
| hsize | output | 3 | Bus transfer size, fixed at word |
| hwdata | output | DW | Bus write data |
| hrdata | input | DW | Bus read data |
| hready | input | 1 | Bus transfer done / slave ready |
| hresp | input | 1 | Bus response, 1 = error |

## Verification
Some properties are checked on every cycle by the assertions. These are: htrans only ever carries IDLE or NONSEQ; a waited address phase keeps its address and direction; write data holds through wait states; a data phase starts only after an accepted address; the ready pulse lasts a single cycle; and no address is issued while a data phase is open. Other behaviour can only be shown by the bench's scenarios, because it depends on the processor's values and on the shared bus. These are: the read data actually arriving on the shared bus, the bridge staying off that bus during stores and idle time, the captured store value matching what the processor drove, the error flag following hresp, and reset in the middle of a transfer.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  // Bus size code for a transfer of the given byte count: log2(bytes).
  function automatic logic [2:0] size_code(input int unsigned nbytes);
    logic [2:0] code;
    code = 3'd0;
    for (int i = 0; i < 8; i++) begin
      if ((32'd1 << i) == nbytes) code = 3'(i);
    end
    return code;
  endfunction

endpackage

// File: rtl/bridge_addr_phase.sv
module bridge_addr_phase
  import bridge_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic          dp_busy,
  input  logic          hready,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic [1:0]    htrans,
  output logic          ap_fire
);

  logic          held_q;
  logic [AW-1:0] haddr_q;
  logic          hwrite_q;
  logic          present;

  // An address phase is on the bus when a waited one is held, or when a
  // fresh request arrives with no data phase open.
  assign present = rst_n && (held_q || (cpu_req && !dp_busy));
  assign haddr   = held_q ? haddr_q  : cpu_addr;
  assign hwrite  = held_q ? hwrite_q : cpu_wr;
  assign htrans  = present ? TR_NONSEQ : TR_IDLE;
  assign ap_fire = present && hready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= 1'b0;
      haddr_q  <= '0;
      hwrite_q <= 1'b0;
    end else if (ap_fire) begin
      held_q   <= 1'b0;
    end else if (present && !held_q) begin
      held_q   <= 1'b1;
      haddr_q  <= haddr;
      hwrite_q <= hwrite;
    end
  end

endmodule

// File: rtl/bridge_data_phase.sv
module bridge_data_phase #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ap_fire,
  input  logic          ap_write,
  input  logic [DW-1:0] bus_in,
  input  logic          hready,
  input  logic          hresp,
  output logic          dp_valid,
  output logic          dp_write,
  output logic          dp_done,
  output logic [DW-1:0] hwdata,
  output logic          cpu_rdy,
  output logic          cpu_err
);

  logic          valid_q;
  logic          write_q;
  logic [DW-1:0] wdata_q;

  assign dp_valid = valid_q;
  assign dp_write = write_q;
  assign dp_done  = valid_q && hready;
  assign hwdata   = wdata_q;
  assign cpu_rdy  = dp_done;
  assign cpu_err  = dp_done && hresp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (ap_fire) begin
      valid_q <= 1'b1;
      write_q <= ap_write;
      if (ap_write) wdata_q <= bus_in;
    end else if (dp_done) begin
      valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bridge_bus_dir.sv
module bridge_bus_dir #(
  parameter int DW = 32
) (
  input  logic          dp_valid,
  input  logic          dp_write,
  input  logic [DW-1:0] hrdata,
  output logic          drive_en,
  output logic [DW-1:0] drive_val
);

  // The direction follows the access that currently owns the data phase.
  assign drive_en  = dp_valid && !dp_write;
  assign drive_val = hrdata;

endmodule

// File: rtl/cpu_ahb_bridge.sv
module cpu_ahb_bridge
  import bridge_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  inout  wire  [DW-1:0] cpu_data,
  output logic          cpu_rdy,
  output logic          cpu_err,
  output logic [AW-1:0] haddr,
  output logic          hwrite,
  output logic [1:0]    htrans,
  output logic [2:0]    hsize,
  output logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hready,
  input  logic          hresp
);

  localparam int          WORD_BYTES = DW / 8;
  localparam logic [2:0]  WORD_SIZE  = size_code(WORD_BYTES);

  logic          ap_fire;
  logic          dp_valid;
  logic          dp_write;
  logic          dp_done;
  logic          rd_drive_en;
  logic [DW-1:0] rd_value;
  logic [DW-1:0] bus_in;

  assign hsize    = WORD_SIZE;
  assign bus_in   = cpu_data;
  assign cpu_data = rd_drive_en ? rd_value : {DW{1'bz}};

  bridge_addr_phase #(.AW(AW)) u_ap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .dp_busy  (dp_valid),
    .hready   (hready),
    .haddr    (haddr),
    .hwrite   (hwrite),
    .htrans   (htrans),
    .ap_fire  (ap_fire)
  );

  bridge_data_phase #(.DW(DW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ap_fire  (ap_fire),
    .ap_write (hwrite),
    .bus_in   (bus_in),
    .hready   (hready),
    .hresp    (hresp),
    .dp_valid (dp_valid),
    .dp_write (dp_write),
    .dp_done  (dp_done),
    .hwdata   (hwdata),
    .cpu_rdy  (cpu_rdy),
    .cpu_err  (cpu_err)
  );

  bridge_bus_dir #(.DW(DW)) u_dir (
    .dp_valid  (dp_valid),
    .dp_write  (dp_write),
    .hrdata    (hrdata),
    .drive_en  (rd_drive_en),
    .drive_val (rd_value)
  );

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    htrans,
  input logic [AW-1:0] haddr,
  input logic          hwrite,
  input logic          hready,
  input logic [DW-1:0] hwdata,
  input logic          cpu_rdy,
  input logic          dp_valid,
  input logic          dp_write,
  input logic          ap_fire
);

  // R1: idle transfer type while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) assert_idle_in_reset_R1: assert (htrans == 2'b00);
  end

  assert_two_codes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b00) || (htrans == 2'b10));

  assert_fire_opens_dp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ap_fire |=> dp_valid);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b10 && !hready) |=> (htrans == 2'b10 && $stable(haddr) && $stable(hwrite)));

  assert_dp_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_valid) |-> $past(htrans == 2'b10 && hready));

  assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && dp_write && !hready) |=> $stable(hwdata));

  assert_rdy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |=> !cpu_rdy);

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid |-> (htrans == 2'b00));

endmodule

bind cpu_ahb_bridge bridge_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .htrans   (htrans),
  .haddr    (haddr),
  .hwrite   (hwrite),
  .hready   (hready),
  .hwdata   (hwdata),
  .cpu_rdy  (cpu_rdy),
  .dp_valid (dp_valid),
  .dp_write (dp_write),
  .ap_fire  (ap_fire)
);

// File: tb/tb_cpu_ahb_bridge.sv
`timescale 1ns/1ps
module tb_cpu_ahb_bridge;

  localparam logic [31:0] IDLE_PAT = 32'h5A5A_5A5A;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [3:0]  waits;
    logic        resp;
    logic        gap;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 32'h0000_0100, 32'h0,         32'hA5A5_0001, 4'd0, 1'b0, 1'b1},
    '{1'b1, 32'h0000_0104, 32'h1234_5678, 32'h0,         4'd2, 1'b0, 1'b0},
    '{1'b0, 32'h0000_0108, 32'h0,         32'hDEAD_BEEF, 4'd1, 1'b1, 1'b0},
    '{1'b1, 32'h0000_010C, 32'hCAFE_F00D, 32'h0,         4'd0, 1'b1, 1'b1},
    '{1'b0, 32'h0000_0203, 32'h0,         32'h0F0F_0F0F, 4'd3, 1'b0, 1'b1},
    '{1'b1, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0,         4'd1, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  wire  [31:0] cpu_data;
  logic        cpu_rdy, cpu_err;
  logic [31:0] haddr;
  logic        hwrite;
  logic [1:0]  htrans;
  logic [2:0]  hsize;
  logic [31:0] hwdata;
  logic [31:0] hrdata = '0;
  logic        hready = 1'b1;
  logic        hresp = 1'b0;
  logic        tb_drv = 1'b0;
  logic [31:0] tb_val = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign cpu_data = tb_drv ? tb_val : 32'hzzzz_zzzz;

  cpu_ahb_bridge dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_wr(cpu_wr), .cpu_data(cpu_data), .cpu_rdy(cpu_rdy), .cpu_err(cpu_err),
    .haddr(haddr), .hwrite(hwrite), .htrans(htrans), .hsize(hsize),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // The bus must not carry the bridge's copy of hrdata when the bridge is off it.
  task automatic chk_off(input string tag);
    checks++;
    if (cpu_data === hrdata) begin
      errors++;
      $display("FAIL %s act=%h exp=not %h", tag, cpu_data, hrdata);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    cpu_req = 1'b0; tb_drv = 1'b0; hready = 1'b1; hresp = 1'b0; hrdata = IDLE_PAT;
    #1;
    chk("R8 rdy drops after one cycle", {31'd0, cpu_rdy}, 32'd0);
    chk("R9 err low when idle", {31'd0, cpu_err}, 32'd0);
    chk("R2 idle htrans", {30'd0, htrans}, 32'd0);
    chk_off("R6 bus released after read / R7 idle");
  endtask

  task automatic do_xfer(input vec_t v);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = v.addr; cpu_wr = v.wr;
    tb_drv = v.wr; tb_val = v.wdata;
    hready = 1'b1; hresp = 1'b0;
    hrdata = v.wr ? IDLE_PAT : v.rdata;
    #1;
    chk("R2 nonseq", {30'd0, htrans}, 32'd2);
    chk("R2 haddr", haddr, v.addr);
    chk("R2 hwrite", {31'd0, hwrite}, {31'd0, v.wr});
    chk("R3 hsize word", {29'd0, hsize}, 32'd2);
    chk("R8 no rdy in addr phase", {31'd0, cpu_rdy}, 32'd0);
    for (int w = 0; w < int'(v.waits); w++) begin
      @(negedge clk);
      hready = 1'b0;
      if (v.wr) tb_val = ~v.wdata;
      #1;
      chk("R8 no rdy in wait", {31'd0, cpu_rdy}, 32'd0);
      chk("R10 idle during data phase", {30'd0, htrans}, 32'd0);
      if (v.wr) begin
        chk("R5 hwdata held in wait", hwdata, v.wdata);
        chk("R7 bus keeps cpu value in store", cpu_data, ~v.wdata);
      end else begin
        chk("R6 read data on bus in wait", cpu_data, v.rdata);
      end
    end
    @(negedge clk);
    hready = 1'b1; hresp = v.resp;
    #1;
    chk("R8 rdy at completion", {31'd0, cpu_rdy}, 32'd1);
    chk("R9 err with rdy", {31'd0, cpu_err}, {31'd0, v.resp});
    if (v.wr) chk("R5 hwdata at completion", hwdata, v.wdata);
    else      chk("R6 read data on bus", cpu_data, v.rdata);
  endtask

  initial begin
    // R1: reset with a request pending
    hrdata = IDLE_PAT;
    cpu_req = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 htrans idle in reset", {30'd0, htrans}, 32'd0);
    chk("R1 rdy low in reset", {31'd0, cpu_rdy}, 32'd0);
    cpu_req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 htrans idle after reset", {30'd0, htrans}, 32'd0);
    chk("R1 err low after reset", {31'd0, cpu_err}, 32'd0);
    chk_off("R1 bus undriven after reset");

    // Table of transfers
    foreach (VECS[i]) begin
      do_xfer(VECS[i]);
      if (VECS[i].gap) go_idle();
    end
    go_idle();

    // R4: address phase held while hready low, processor changes its inputs
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 32'h0000_0400; cpu_wr = 1'b0; hready = 1'b0;
    hrdata = 32'h7777_1111;
    #1;
    chk("R4 nonseq presented", {30'd0, htrans}, 32'd2);
    @(negedge clk);
    cpu_addr = 32'h0000_0800; cpu_wr = 1'b1;
    #1;
    chk("R4 haddr held", haddr, 32'h0000_0400);
    chk("R4 hwrite held", {31'd0, hwrite}, 32'd0);
    @(negedge clk);
    hready = 1'b1;
    #1;
    chk("R4 haddr held at accept", haddr, 32'h0000_0400);
    @(negedge clk); #1;
    chk("R4 held read completes", {31'd0, cpu_rdy}, 32'd1);
    chk("R6 held read drives bus", cpu_data, 32'h7777_1111);
    go_idle();

    // R1: reset in the middle of a read data phase
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 32'h0000_0500; cpu_wr = 1'b0; hrdata = 32'h2222_3333;
    @(negedge clk);
    hready = 1'b0;
    #1;
    chk("R6 read bus driven before reset", cpu_data, 32'h2222_3333);
    rst_n = 1'b0;
    #1;
    chk("R1 bus released on reset", {31'd0, (cpu_data === 32'h2222_3333)}, 32'd0);
    chk("R1 htrans idle on reset", {30'd0, htrans}, 32'd0);
    chk("R1 rdy low on reset", {31'd0, cpu_rdy}, 32'd0);
    @(negedge clk);
    cpu_req = 1'b0; hready = 1'b1;
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 idle after mid reset", {30'd0, htrans}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule